// File: doc/BRIEF.md
# Staggered Scan Shift Controller

This block drives a scan chain that is split into two halves of equal length, A and B, so that only one half moves in any shift cycle. A single phase bit toggles on every shift cycle. It gates the two halves so that each is enabled on alternate system clock cycles. Each half therefore shifts at half the system rate, and the two enable streams have the same period but sit one cycle apart. Both halves see the same serial input, and only the enabled half takes the bit, so the input stream is dealt out to A and B in turn.

A serial-output multiplexer follows the same phase. It presents the last cell of half A in A-phase cycles and the last cell of half B in B-phase cycles, so its select flips on every shift cycle. The tester therefore sees one ordered bit stream. That stream is exactly as long as the stream of a single conventional chain holding all 2×HALF_LEN cells.

When scan enable is low, the block is in capture: both halves are enabled on every cycle and load their parallel inputs together. The enables are modelled as clock enables on flops in the one system clock domain.

Top module: `stagger_scan_ctrl`

## Requirements
- R1: After reset every cell of both halves holds 0, `out_sel` is 0 and the phase points at half A, so the first shift cycle after reset enables A.
- R2: While `scan_en` is high, `en_a` and `en_b` alternate on every cycle. The first cycle with `scan_en` high enables A only, and the next one enables B only.
- R3: In no cycle with `scan_en` high are `en_a` and `en_b` both 1.
- R4: While `scan_en` is low, `en_a` and `en_b` are both 1. At the next clock edge every cell loads its parallel input, `cap_a[i]` into cell i of A and `cap_b[i]` into cell i of B.
- R5: In a shift cycle the enabled half moves one place toward index HALF_LEN-1 and takes `scan_in` into index 0. The other half keeps its contents.
- R6: In shift, `out_sel` is 1 exactly when half B is enabled, and it flips on every shift cycle. `scan_out` equals cell HALF_LEN-1 of the half that `out_sel` picks, with 0 meaning A and 1 meaning B.
- R7: A bit presented on `scan_in` in shift cycle t appears on `scan_out` in shift cycle t+2×HALF_LEN. The order of the stream is kept, which matches a single chain of 2×HALF_LEN cells.
- R8: After one capture cycle, the next 2×HALF_LEN shift cycles put out the captured values in this order: output bit 2j is `cap_a[HALF_LEN-1-j]` and output bit 2j+1 is `cap_b[HALF_LEN-1-j]`.
- R9: A shift burst of any length, odd lengths included, followed by at least one capture cycle, leaves the phase set so that the next shift burst begins with half A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_en | input | 1 | 1 = shift, 0 = capture |
| scan_in | input | 1 | Serial scan data from the tester |
| cap_a | input | HALF_LEN | Parallel capture data for half A |
| cap_b | input | HALF_LEN | Parallel capture data for half B |
| par_a | output | HALF_LEN | Cell contents of half A, index 0 at the input end |
| par_b | output | HALF_LEN | Cell contents of half B, index 0 at the input end |
| en_a | output | 1 | Update enable of half A |
| en_b | output | 1 | Update enable of half B |
| out_sel | output | 1 | Output multiplexer select, 1 = half B |
| scan_out | output | 1 | Serial scan data to the tester |

## Verification
Random patterns are captured and then shifted out. The expected order of the unloaded bits tells apart a correct interleave from a swapped select or a reversed half. Random serial streams are then pushed through a full 2×HALF_LEN shift, which shows whether the input is dealt to the right half and whether the total delay equals that of one chain. A directed odd-length burst followed by a single capture cycle shows whether the phase really restarts on half A. A long stretch with scan enable and both data inputs random, compared cycle by cycle with a bench model, catches enables that overlap or a half that moves out of turn.

// File: rtl/stagger_scan_pkg.sv
package stagger_scan_pkg;

    // Which half of the chain moves in the current shift cycle
    typedef enum logic {
        PH_A = 1'b0,
        PH_B = 1'b1
    } phase_e;

    // Registered state of the phase generator
    typedef struct packed {
        phase_e ph;
    } phase_st_t;

endpackage

// File: rtl/stagger_phase_gen.sv
module stagger_phase_gen
    import stagger_scan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scan_en,
    output logic en_a,
    output logic en_b,
    output logic sel_b
);

    phase_st_t st_d, st_q;
    logic      is_b;

    always_comb begin
        st_d = st_q;
        is_b = (st_q.ph == PH_B);
        // Toggle while shifting; hold at A in capture so every burst starts on A
        if (scan_en) begin
            st_d.ph = is_b ? PH_A : PH_B;
        end else begin
            st_d.ph = PH_A;
        end
        // AND-type masking of every second cycle during shift
        en_a  = ~scan_en | ~is_b;
        en_b  = ~scan_en |  is_b;
        sel_b =  scan_en &  is_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_A};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/stagger_scan_half.sv
module stagger_scan_half #(
    parameter int LEN = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           load,
    input  logic           sin,
    input  logic [LEN-1:0] par_in,
    output logic [LEN-1:0] cells,
    output logic           sout
);

    logic [LEN-1:0] cells_d, cells_q;

    always_comb begin
        cells_d = cells_q;
        if (en) begin
            if (load) begin
                cells_d = par_in;
            end else begin
                cells_d = {cells_q[LEN-2:0], sin};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cells_q <= '0;
        end else begin
            cells_q <= cells_d;
        end
    end

    assign cells = cells_q;
    assign sout  = cells_q[LEN-1];

endmodule

// File: rtl/stagger_out_mux.sv
module stagger_out_mux (
    input  logic sel_b,
    input  logic last_a,
    input  logic last_b,
    output logic sout
);

    always_comb begin
        sout = sel_b ? last_b : last_a;
    end

endmodule

// File: rtl/stagger_scan_ctrl.sv
module stagger_scan_ctrl #(
    parameter int HALF_LEN = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scan_en,
    input  logic                scan_in,
    input  logic [HALF_LEN-1:0] cap_a,
    input  logic [HALF_LEN-1:0] cap_b,
    output logic [HALF_LEN-1:0] par_a,
    output logic [HALF_LEN-1:0] par_b,
    output logic                en_a,
    output logic                en_b,
    output logic                out_sel,
    output logic                scan_out
);

    localparam int NUM_HALVES = 2;

    logic [NUM_HALVES-1:0]               en_vec;
    logic [NUM_HALVES-1:0]               last_vec;
    logic [NUM_HALVES-1:0][HALF_LEN-1:0] cap_vec;
    logic [NUM_HALVES-1:0][HALF_LEN-1:0] cell_vec;

    stagger_phase_gen u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .scan_en (scan_en),
        .en_a    (en_vec[0]),
        .en_b    (en_vec[1]),
        .sel_b   (out_sel)
    );

    assign cap_vec[0] = cap_a;
    assign cap_vec[1] = cap_b;

    for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
        stagger_scan_half #(.LEN(HALF_LEN)) u_half (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en_vec[g]),
            .load   (~scan_en),
            .sin    (scan_in),
            .par_in (cap_vec[g]),
            .cells  (cell_vec[g]),
            .sout   (last_vec[g])
        );
    end

    stagger_out_mux u_mux (
        .sel_b  (out_sel),
        .last_a (last_vec[0]),
        .last_b (last_vec[1]),
        .sout   (scan_out)
    );

    assign en_a  = en_vec[0];
    assign en_b  = en_vec[1];
    assign par_a = cell_vec[0];
    assign par_b = cell_vec[1];

endmodule

// File: rtl/stagger_scan_ctrl_chk.sv
module stagger_scan_ctrl_chk #(
    parameter int HALF_LEN = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                scan_en,
    input logic                scan_in,
    input logic [HALF_LEN-1:0] cap_a,
    input logic [HALF_LEN-1:0] cap_b,
    input logic [HALF_LEN-1:0] par_a,
    input logic [HALF_LEN-1:0] par_b,
    input logic                en_a,
    input logic                en_b,
    input logic                out_sel,
    input logic                scan_out
);

    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |-> !(en_a && en_b));

    assert_a_then_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && en_a) |=> (!scan_en || (en_b && !en_a)));

    assert_b_then_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && en_b) |=> (!scan_en || (en_a && !en_b)));

    assert_restart_on_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en) |=> (!scan_en || (en_a && !en_b)));

    assert_capture_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |-> (en_a && en_b));

    assert_capture_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> (par_a == $past(cap_a) && par_b == $past(cap_b)));

    assert_shift_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && en_a) |=>
            (par_a == {$past(par_a[HALF_LEN-2:0]), $past(scan_in)} && $stable(par_b)));

    assert_shift_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && en_b) |=>
            (par_b == {$past(par_b[HALF_LEN-2:0]), $past(scan_in)} && $stable(par_a)));

    assert_sel_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> (!scan_en || out_sel != $past(out_sel)));

    assert_out_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |-> (scan_out == (out_sel ? par_b[HALF_LEN-1] : par_a[HALF_LEN-1])));

endmodule

bind stagger_scan_ctrl stagger_scan_ctrl_chk #(.HALF_LEN(HALF_LEN)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scan_en  (scan_en),
    .scan_in  (scan_in),
    .cap_a    (cap_a),
    .cap_b    (cap_b),
    .par_a    (par_a),
    .par_b    (par_b),
    .en_a     (en_a),
    .en_b     (en_b),
    .out_sel  (out_sel),
    .scan_out (scan_out)
);

// File: tb/stagger_scan_ctrl_tb_top.sv
module stagger_scan_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int ROUNDS     = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scan_en = 1'b0;
    logic         scan_in = 1'b0;
    logic [N-1:0] cap_a = '0;
    logic [N-1:0] cap_b = '0;
    logic [N-1:0] par_a, par_b;
    logic         en_a, en_b, out_sel, scan_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Bench model, built from the requirements
    logic [N-1:0] ea = '0;
    logic [N-1:0] eb = '0;
    logic         bph = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stagger_scan_ctrl #(.HALF_LEN(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
        .cap_a(cap_a), .cap_b(cap_b), .par_a(par_a), .par_b(par_b),
        .en_a(en_a), .en_b(en_b), .out_sel(out_sel), .scan_out(scan_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [N-1:0] shift_in(input logic [N-1:0] v, input logic b);
        return {v[N-2:0], b};
    endfunction

    // One system cycle: drive at negedge, check outputs, then check state after the edge
    task automatic cyc(input logic se, input logic si, input logic [N-1:0] ca,
                       input logic [N-1:0] cb, input string first_req, output logic so);
        logic pb;
        @(negedge clk);
        scan_en = se; scan_in = si; cap_a = ca; cap_b = cb;
        #1;
        pb = bph;
        so = scan_out;
        if (se) begin
            chk(en_a == !pb && en_b == pb, first_req, {en_a, en_b}, {!pb, pb});
            chk(!(en_a && en_b), "R3", {en_a, en_b}, 2'b00);
            chk(out_sel == pb, "R6", out_sel, pb);
            chk(scan_out == (pb ? eb[N-1] : ea[N-1]), "R6", scan_out, pb ? eb[N-1] : ea[N-1]);
            if (pb) eb = shift_in(eb, si);
            else    ea = shift_in(ea, si);
            bph = ~pb;
        end else begin
            chk(en_a && en_b, "R4", {en_a, en_b}, 2'b11);
            ea = ca; eb = cb;
            bph = 1'b0;
        end
        @(posedge clk);
        #1;
        chk(par_a == ea && par_b == eb, se ? "R5" : "R4", {par_a, par_b}, {ea, eb});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic         so;
        logic [N-1:0] ca, cb;
        logic [4*N-1:0] fed;
        void'($urandom(32'd4711));

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(par_a == '0 && par_b == '0, "R1", {par_a, par_b}, '0);
        chk(out_sel == 1'b0, "R1", out_sel, 1'b0);
        scan_en = 1'b1;
        #1;
        chk(en_a && !en_b, "R1", {en_a, en_b}, 2'b10);
        scan_en = 1'b0;

        // R8 and R7: capture random data, unload it, then push a full stream through
        for (int r = 0; r < ROUNDS; r++) begin
            ca = N'($urandom);
            cb = N'($urandom);
            if (r == 0) begin ca = '1; cb = '0; end
            if (r == 1) begin ca = 8'hA5; cb = 8'h3C; end
            cyc(1'b0, 1'b0, ca, cb, "R4", so);
            for (int k = 0; k < 4*N; k++) begin
                fed[k] = 1'($urandom);
                cyc(1'b1, fed[k], ca, cb, (k == 0) ? "R9" : "R2", so);
                if (k < 2*N) begin
                    if (k % 2 == 0) chk(so == ca[N-1-k/2], "R8", so, ca[N-1-k/2]);
                    else            chk(so == cb[N-1-k/2], "R8", so, cb[N-1-k/2]);
                end else begin
                    chk(so == fed[k-2*N], "R7", so, fed[k-2*N]);
                end
            end
        end

        // R9: odd-length burst, one capture cycle, then the new burst starts on A
        for (int k = 0; k < 3; k++) cyc(1'b1, 1'($urandom), '0, '0, "R2", so);
        cyc(1'b0, 1'b0, 8'h0F, 8'hF0, "R4", so);
        cyc(1'b1, 1'b1, '0, '0, "R9", so);
        cyc(1'b1, 1'b0, '0, '0, "R2", so);

        // Mixed random traffic checked against the model
        for (int k = 0; k < 400; k++) begin
            cyc(($urandom % 5) != 0, 1'($urandom), N'($urandom), N'($urandom), "R2", so);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule